// File: doc/BRIEF.md
# Ring-Compare Response Analyzer Array with Scan Readout

This block watches the outputs of N identical units that are being tested side by side. It holds one result flip-flop per pair of neighbouring units. The pairs close into a ring, so each unit takes part in two comparisons. While a test runs, any cycle in which the two units of a pair disagree sets that pair's result bit. The bit then stays set until it is cleared on purpose. A faulty unit therefore shows up as two adjacent set bits. A fault in the wiring or in a comparator shows up as a single set bit or as an irregular pattern, which downstream diagnosis can pick out.

The result flip-flops also form a serial chain. With the shift select high, the latched bits leave through a single output, lowest analyzer first, and new bits enter at the far end. Results can then be read with one pin instead of N. A synchronous clear zeroes every bit before a new run.

Top module: `ora_ring_scan`

## Requirements
- R1: While `test_en` is 1 and `shift_en` and `clr` are 0, a clock edge at which the two units of a pair differ sets that pair's result bit to 1.
- R2: A result bit of 1 stays 1 through any number of capture or idle cycles until a clear or a shift replaces it.
- R3: Result bit k (k = 0..N-1) compares unit k with unit (k+1) mod N. A single unit that differs from all the others sets exactly bits k-1 (mod N) and k, and these include the wrap pair (N-1, 0).
- R4: While `test_en` is 0 and `shift_en` is 0, result bits do not change, whatever the unit inputs are.
- R5: `clr` = 1 zeroes every result bit at the next clock edge and takes priority over shift and capture.
- R6: While `shift_en` is 1 and `clr` is 0, each clock edge moves bit k+1 into bit k and `scan_in` into bit N-1. `scan_out` always shows bit 0, so analyzer 0's result leaves first. No capture happens while shifting.
- R7: An active-low `rst_n` clears all result bits and `scan_out` at once. The internal reset is released two clock edges after `rst_n` rises.
- R8: A mismatch that lasts a single cycle is still present when the whole chain is shifted out, and it appears at `scan_out` in its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_out | input | N | Outputs of the units under test, bit k is unit k |
| test_en | input | 1 | Enables capture of mismatches |
| clr | input | 1 | Synchronous clear of all result bits |
| shift_en | input | 1 | Selects serial shift instead of capture |
| scan_in | input | 1 | Serial input at the far end of the chain (bit N-1) |
| result | output | N | Latched pass/fail bits, 1 means a mismatch was seen |
| scan_out | output | 1 | Serial output, equal to result bit 0 |

## Verification
Single stuck units are placed at the first, middle and last positions. A design whose ring does not wrap, or whose neighbour index is off by one, marks the wrong pair or only one bit. Alternating and block patterns check every pair at once. Mismatches that last one cycle, followed by quiet input, catch a design that does not hold the bit or that recomputes it each cycle. A shift-out while the inputs keep differing and capture stays enabled catches a shift direction that is reversed, a chain end that is wrong, or capture leaking into shift mode. A clear raised together with shift and capture catches a design with the wrong priority.

// File: rtl/ora_pkg.sv
package ora_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_SHIFT   = 2'd2,
    MODE_CLEAR   = 2'd3
  } ora_mode_e;

  // Clear beats shift, shift beats capture (R5, R6).
  function automatic ora_mode_e decode_mode(input logic clr_i,
                                            input logic shift_i,
                                            input logic test_i);
    ora_mode_e m;
    if (clr_i)        m = MODE_CLEAR;
    else if (shift_i) m = MODE_SHIFT;
    else if (test_i)  m = MODE_CAPTURE;
    else              m = MODE_HOLD;
    return m;
  endfunction

endpackage

// File: rtl/ora_rst_sync.sv
module ora_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ora_cell.sv
module ora_cell
  import ora_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ora_mode_e mode,
  input  logic      lhs,
  input  logic      rhs,
  input  logic      chain_in,
  output logic      res_q
);

  logic res_d;
  logic res_en;

  always_comb begin
    res_en = 1'b1;
    res_d  = res_q;
    unique case (mode)
      MODE_CLEAR:   res_d = 1'b0;
      MODE_SHIFT:   res_d = chain_in;
      MODE_CAPTURE: res_d = res_q | (lhs ^ rhs);
      default:      res_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= 1'b0;
    else if (res_en) res_q <= res_d;
  end

  // R1: a disagreement during capture sets the bit
  assert_set_on_diff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CAPTURE && lhs != rhs) |=> res_q);

  // R2: a set bit survives capture cycles
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CAPTURE && res_q) |=> res_q);

  // R4: idle mode leaves the bit alone
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(res_q));

  // R5: clear zeroes the bit
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |=> !res_q);

  // R6: shift takes the chain neighbour's value
  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT) |=> (res_q == $past(chain_in)));

endmodule

// File: rtl/ora_ring_scan.sv
module ora_ring_scan
  import ora_pkg::*;
#(
  parameter int N           = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] unit_out,
  input  logic         test_en,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         scan_in,
  output logic [N-1:0] result,
  output logic         scan_out
);

  localparam int LAST = N - 1;

  logic      rst_sync_n;
  ora_mode_e mode;
  logic [N-1:0] chain;

  ora_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    mode = decode_mode(clr, shift_en, test_en);
  end

  for (genvar k = 0; k < N; k++) begin : g_cell
    localparam int NXT = (k + 1) % N;
    if (k == LAST) begin : g_tail
      assign chain[k] = scan_in;
    end else begin : g_body
      assign chain[k] = result[k+1];
    end
    ora_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .mode     (mode),
      .lhs      (unit_out[k]),
      .rhs      (unit_out[NXT]),
      .chain_in (chain[k]),
      .res_q    (result[k])
    );
  end

  assign scan_out = result[0];

  // R3: the wrap pair compares the last unit with the first
  assert_ring_wrap_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_CAPTURE && unit_out[LAST] != unit_out[0]) |=> result[LAST]);

  // R6: scan_in lands at the far end after a shift
  assert_scan_entry_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_SHIFT) |=> (result[LAST] == $past(scan_in)));

endmodule

// File: tb/ora_ring_scan_tb.sv
`timescale 1ns/1ps
module ora_ring_scan_tb;

  localparam int N = 9;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] unit_out = '0;
  logic test_en = 1'b0;
  logic clr = 1'b0;
  logic shift_en = 1'b0;
  logic scan_in = 1'b0;
  logic [N-1:0] result;
  logic scan_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ora_ring_scan #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .unit_out(unit_out), .test_en(test_en),
    .clr(clr), .shift_en(shift_en), .scan_in(scan_in),
    .result(result), .scan_out(scan_out)
  );

  // {units, test_en, expected result after one pulse}
  localparam logic [18:0] VEC [NV] = '{
    {9'h000, 1'b1, 9'h000},
    {9'h1FF, 1'b1, 9'h000},
    {9'h001, 1'b1, 9'h101},
    {9'h100, 1'b1, 9'h180},
    {9'h010, 1'b1, 9'h018},
    {9'h155, 1'b1, 9'h0FF},
    {9'h0AA, 1'b1, 9'h0FF},
    {9'h00F, 1'b1, 9'h108},
    {9'h155, 1'b0, 9'h000}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step();
    clr = 1'b0;
  endtask

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] held;
    repeat (2) @(negedge clk);
    check("R7 reset result", result, '0);
    check("R7 reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);
    rst_n = 1'b1;
    repeat (4) step();

    // Table walk: R1, R3, R4
    for (int v = 0; v < NV; v++) begin
      do_clear();
      unit_out = VEC[v][18:10];
      test_en  = VEC[v][9];
      step();
      test_en  = 1'b0;
      unit_out = '0;
      step();
      check(VEC[v][9] ? "R1/R3 capture vector" : "R4 no capture when disabled",
            result, VEC[v][8:0]);
    end

    // R2 and R8: one-cycle mismatch, then quiet input with capture on
    do_clear();
    unit_out = 9'h001;
    test_en  = 1'b1;
    step();
    unit_out = '0;
    repeat (3) step();
    test_en = 1'b0;
    check("R2 sticky after quiet input", result, 9'h101);

    // R6/R8: shift out while inputs differ and capture is requested
    held     = 9'h101;
    pat      = 9'h0A5;
    unit_out = 9'h155;
    test_en  = 1'b1;
    shift_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      check("R8 scan_out order", {{(N-1){1'b0}}, scan_out},
            {{(N-1){1'b0}}, held[k]});
      scan_in = pat[k];
      step();
    end
    shift_en = 1'b0;
    test_en  = 1'b0;
    unit_out = '0;
    check("R6 shifted-in contents", result, pat);

    // R5: clear wins over shift and capture
    clr = 1'b1; shift_en = 1'b1; test_en = 1'b1; unit_out = 9'h0F0; scan_in = 1'b1;
    step();
    clr = 1'b0; shift_en = 1'b0; test_en = 1'b0; unit_out = '0;
    check("R5 clear priority", result, '0);

    // R7: asynchronous reset in the middle of a run
    unit_out = 9'h010; test_en = 1'b1;
    step();
    test_en = 1'b0; unit_out = '0;
    rst_n = 1'b0;
    #1;
    check("R7 async reset", result, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule